// File: doc/BRIEF.md
# Serial-Loaded DAC Input Register Front-End

This block is the digital input logic of a serial-loaded voltage-output converter. A 16-bit word arrives bit by bit on a serial data pin. The bits are taken on the falling edges of a serial clock while an active-low frame strobe is held low, most significant bit first. A DAC register holds the code that drives the converter. The analog ladder and the output amplifier lie outside this block. The converter output is modelled as the applied code plus a flag that shows the output is forced to ground.

An active-low load strobe selects the update mode. The block samples the strobe when the frame strobe falls. If the strobe is low, the DAC register takes the new code when the frame closes. If it is high, the code waits in a holding register until the strobe is later driven low. An active-low read request copies the DAC register into the shift register on the next serial clock fall and shifts it out on the serial output. When no readback is in use, the serial output repeats each input bit 16 serial clocks later, which lets parts be chained. An active-low clear forces the output to ground and leaves both registers intact. A power-down input is passed through as a status level.

All pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected in the system clock domain. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `serial_dac_frontend`

## Requirements
- R1: A frame of exactly 16 serial clock falls, taken MSB first while `frameN` is low, is accepted when `frameN` rises. If `loadN` was low when `frameN` fell, `code` takes the data field of that word.
- R2: With `RES`=14 the data field is word bits 13..0. With `RES`=12 it is bits 13..2. Bits 15 and 14 are always ignored, and with `RES`=12 bits 1 and 0 are ignored as well.
- R3: If `loadN` was high when `frameN` fell, the rise of `frameN` leaves `code` unchanged. The accepted field is applied as soon as `loadN` is later seen low.
- R4: If `frameN` rises after fewer than 16 falls, the frame is discarded. `code` does not change, and a later low on `loadN` applies nothing.
- R5: While `frameN` is low and no readback is under way, each bit shifted in appears on `serOut` at the 16th serial clock fall after it entered. Before any data has entered, `serOut` shows 0.
- R6: After `readN` falls, the next serial clock fall puts bit 15 of the readback word on `serOut`. Each of the following 15 falls puts out the next lower bit. The readback word holds the DAC register aligned to its data field, with bits 15 and 14 equal to 0 and unused low bits equal to 0.
- R7: A fall of `clearN` sets `isCleared` and leaves `code` and the held input code unchanged.
- R8: Once `clearN` is high, `isCleared` stays set until `loadN` is seen low. If `loadN` is held low, `isCleared` drops as soon as `clearN` returns high.
- R9: `isAsleep` follows `sleep`, and power-down leaves `code` unchanged.
- R10: After reset, `code` is 0, `isCleared` is 0, `isAsleep` is 0 and `serOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edges |
| frameN | input | 1 | Active-low frame strobe |
| serData | input | 1 | Serial data in |
| loadN | input | 1 | Active-low load strobe, also selects the update mode |
| readN | input | 1 | Active-low readback request |
| clearN | input | 1 | Active-low clear to ground |
| sleep | input | 1 | Power-down request |
| serOut | output | 1 | Serial data out (pass-through or readback) |
| code | output | RES | Code applied by the DAC register |
| isCleared | output | 1 | Output is forced to ground |
| isAsleep | output | 1 | Power-down is active |

## Verification
The embedded properties check on every cycle that the frame bit count never exceeds 16 and that a deferred frame leaves an update pending. They also check that a readback always starts with a zero bit, that the DAC register changes only on a commit or deferred-load strobe, and that a clear persists until its release condition. Scenario checks alone can show the rest: the data field for each resolution, the choice of mode from the load strobe sampled at frame start, and discarding of short frames. The same holds for the 16-clock delay on the serial output, the bit order of a readback, and the two ways of leaving the clear state.

// File: rtl/serial_dac_pkg.sv
package serial_dac_pkg;
  localparam int WORD_BITS = 16;

  typedef struct packed {
    logic shiftEn;
    logic rbLoad;
    logic commitHold;
    logic commitDac;
    logic loadHold;
    logic clearSet;
    logic clearRelease;
  } dacStrobe_t;
endpackage

// File: rtl/serial_dac_sync.sv
module serial_dac_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RESET_VAL[i];
        stage2 <= RESET_VAL[i];
      end else begin
        stage1 <= din[i];
        stage2 <= stage1;
      end
    end
    assign dout[i] = stage2;
  end
endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl
  import serial_dac_pkg::*;
#(
  parameter int WORD = WORD_BITS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       frameN,
  input  logic       serData,
  input  logic       loadN,
  input  logic       readN,
  input  logic       clearN,
  input  logic       sleep,
  output dacStrobe_t st,
  output logic       dataSync,
  output logic       sleepSync
);
  localparam int CNT_W = $clog2(WORD + 1);
  localparam int NPIN = 7;
  localparam logic [NPIN-1:0] PIN_IDLE = 7'b0011110;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD);
  localparam logic [CNT_W-1:0] RB_REST = CNT_W'(WORD - 1);

  logic [NPIN-1:0] pinRaw, pinSync, pinPrev;
  assign pinRaw = {serData, sleep, clearN, readN, loadN, frameN, serClk};

  serial_dac_sync #(.WIDTH(NPIN), .RESET_VAL(PIN_IDLE)) i_sync (
    .clk(clk), .rstN(rstN), .din(pinRaw), .dout(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= PIN_IDLE;
    else       pinPrev <= pinSync;
  end

  logic sclkFall, frameFall, frameRise, frameLow, readFall, clearFall;
  logic loadLow, readLow, clearHigh;
  assign sclkFall  = pinPrev[0] & ~pinSync[0];
  assign frameFall = pinPrev[1] & ~pinSync[1];
  assign frameRise = ~pinPrev[1] & pinSync[1];
  assign frameLow  = ~pinSync[1];
  assign loadLow   = ~pinSync[2];
  assign readFall  = pinPrev[3] & ~pinSync[3];
  assign readLow   = ~pinSync[3];
  assign clearFall = pinPrev[4] & ~pinSync[4];
  assign clearHigh = pinSync[4];
  assign sleepSync = pinSync[5];
  assign dataSync  = pinSync[6];

  logic [CNT_W-1:0] bitCnt, rbLeft;
  logic asyncMode, pending, rbArm, frameOk;

  assign frameOk = frameRise && (bitCnt == FULL);

  always_comb begin
    st              = '0;
    st.rbLoad       = sclkFall && rbArm && readLow;
    st.shiftEn      = sclkFall && !st.rbLoad && (frameLow || rbLeft != '0);
    st.commitHold   = frameOk;
    st.commitDac    = frameOk && !asyncMode;
    st.loadHold     = pending && loadLow;
    st.clearSet     = clearFall;
    st.clearRelease = clearHigh && loadLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      asyncMode <= 1'b0;
      pending   <= 1'b0;
      rbArm     <= 1'b0;
      rbLeft    <= '0;
    end else begin
      if (frameFall) begin
        bitCnt    <= '0;
        asyncMode <= ~loadLow;
      end else if (sclkFall && frameLow && bitCnt != FULL) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (frameOk && asyncMode)        pending <= 1'b1;
      else if (st.loadHold || st.commitDac) pending <= 1'b0;

      if (readFall)       rbArm <= 1'b1;
      else if (st.rbLoad) rbArm <= 1'b0;

      if (st.rbLoad)                      rbLeft <= RB_REST;
      else if (sclkFall && rbLeft != '0)  rbLeft <= rbLeft - 1'b1;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);

  assert_async_defers_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitHold && asyncMode) |=> pending);
endmodule

// File: rtl/serial_dac_datapath.sv
module serial_dac_datapath
  import serial_dac_pkg::*;
#(
  parameter int WORD = WORD_BITS,
  parameter int RES  = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  dacStrobe_t     st,
  input  logic           dataBit,
  output logic [RES-1:0] dacReg,
  output logic           clearedQ,
  output logic           sdoQ
);
  localparam int TOP = WORD - 3;
  localparam int LSB = WORD - 2 - RES;

  logic [WORD-1:0] shiftReg, rbWord;
  logic [RES-1:0]  holdReg, field;

  assign field  = shiftReg[TOP -: RES];
  assign rbWord = {{(WORD - RES){1'b0}}, dacReg} << LSB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoQ     <= 1'b0;
      holdReg  <= '0;
      dacReg   <= '0;
      clearedQ <= 1'b0;
    end else begin
      if (st.rbLoad) begin
        shiftReg <= {rbWord[WORD-2:0], dataBit};
        sdoQ     <= rbWord[WORD-1];
      end else if (st.shiftEn) begin
        shiftReg <= {shiftReg[WORD-2:0], dataBit};
        sdoQ     <= shiftReg[WORD-1];
      end

      if (st.commitHold) holdReg <= field;

      if (st.commitDac)     dacReg <= field;
      else if (st.loadHold) dacReg <= holdReg;

      if (st.clearSet)          clearedQ <= 1'b1;
      else if (st.clearRelease) clearedQ <= 1'b0;
    end
  end

  assert_readback_zero_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.rbLoad |=> !sdoQ);

  assert_code_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(st.commitDac) && !$past(st.loadHold)) |-> $stable(dacReg));

  assert_clear_persists_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clearedQ) && !$past(st.clearRelease)) |-> clearedQ);
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import serial_dac_pkg::*;
#(
  parameter int RES = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           frameN,
  input  logic           serData,
  input  logic           loadN,
  input  logic           readN,
  input  logic           clearN,
  input  logic           sleep,
  output logic           serOut,
  output logic [RES-1:0] code,
  output logic           isCleared,
  output logic           isAsleep
);
  dacStrobe_t st;
  logic dataSync;

  serial_dac_ctrl #(.WORD(WORD_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .frameN(frameN),
    .serData(serData), .loadN(loadN), .readN(readN), .clearN(clearN),
    .sleep(sleep), .st(st), .dataSync(dataSync), .sleepSync(isAsleep)
  );

  serial_dac_datapath #(.WORD(WORD_BITS), .RES(RES)) i_datapath (
    .clk(clk), .rstN(rstN), .st(st), .dataBit(dataSync),
    .dacReg(code), .clearedQ(isCleared), .sdoQ(serOut)
  );
endmodule

// File: tb/test_serial_dac_frontend.sv
module test_serial_dac_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, frameN = 1'b1, serData = 1'b0;
  logic loadN = 1'b1, readN = 1'b1, clearN = 1'b1, sleep = 1'b0;
  logic serOut, serOut12, isCleared, isCleared12, isAsleep, isAsleep12;
  logic [13:0] code;
  logic [11:0] code12;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit pipe[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_dac_frontend #(.RES(14)) i_serial_dac_frontend (
    .clk(clk), .rstN(rstN), .serClk(serClk), .frameN(frameN), .serData(serData),
    .loadN(loadN), .readN(readN), .clearN(clearN), .sleep(sleep),
    .serOut(serOut), .code(code), .isCleared(isCleared), .isAsleep(isAsleep)
  );

  serial_dac_frontend #(.RES(12)) i_serial_dac_frontend_12 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .frameN(frameN), .serData(serData),
    .loadN(loadN), .readN(readN), .clearN(clearN), .sleep(sleep),
    .serOut(serOut12), .code(code12), .isCleared(isCleared12), .isAsleep(isAsleep12)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock pulse; when track is set, compare serOut with the 16-deep model
  task automatic serialBit(input logic b, input bit track, input string req);
    serData = b;
    serClk = 1'b1;
    waitClk(PHASE);
    serClk = 1'b0;
    waitClk(PHASE + 1);
    if (track) begin
      bit e;
      e = pipe.pop_front();
      pipe.push_back(b);
      check(req, serOut, e);
    end
  endtask

  task automatic sendFrame(input logic [15:0] w, input logic ldAtStart, input int nBits,
                           input string req);
    loadN = ldAtStart;
    waitClk(PHASE);
    frameN = 1'b0;
    waitClk(PHASE);
    for (int i = 0; i < nBits; i++) serialBit(w[15 - i], 1'b1, req);
    frameN = 1'b1;
    waitClk(2 * PHASE);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pipe.push_back(1'b0);
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    // R10 reset state
    check("R10 code", code, 0);
    check("R10 cleared", isCleared, 0);
    check("R10 asleep", isAsleep, 0);
    check("R10 serOut", serOut, 0);

    // R1 R2 synchronous update, R5 serOut shows zeros before data
    sendFrame(16'hC123, 1'b0, 16, "R5 initial zeros");
    check("R1 sync load 14", code, 14'h0123);
    check("R2 field 12", code12, 12'h048);

    // R5 pass-through of previous frame, R1 R2 second pattern
    sendFrame(16'h3A5C, 1'b0, 16, "R5 pass-through");
    check("R1 sync load 14 b", code, 14'h3A5C);
    check("R2 field 12 b", code12, 12'hE97);

    // R3 deferred update
    sendFrame(16'h1234, 1'b1, 16, "R5 pass-through c");
    check("R3 no load at frame end", code, 14'h3A5C);
    check("R3 no load at frame end 12", code12, 12'hE97);
    loadN = 1'b0;
    waitClk(2 * PHASE);
    check("R3 load on strobe", code, 14'h1234);
    check("R3 load on strobe 12", code12, 12'h48D);
    loadN = 1'b1;
    waitClk(PHASE);

    // R4 short frames are discarded
    sendFrame(16'h2FFF, 1'b1, 9, "R5 short frame shift");
    loadN = 1'b0;
    waitClk(2 * PHASE);
    check("R4 async short frame", code, 14'h1234);
    sendFrame(16'h0F0F, 1'b0, 5, "R5 short frame shift b");
    check("R4 sync short frame", code, 14'h1234);
    check("R4 sync short frame 12", code12, 12'h48D);
    loadN = 1'b1;
    waitClk(PHASE);

    // R6 readback of the DAC register
    readN = 1'b0;
    waitClk(2 * PHASE);
    pipe.delete();
    begin
      logic [15:0] rb;
      rb = 16'h1234;
      for (int i = 15; i >= 0; i--) pipe.push_back(rb[i]);
    end
    check("R6 top bits zero", pipe[0] | pipe[1], 0);
    for (int i = 0; i < 16; i++) serialBit(1'b0, 1'b1, "R6 readback bit");
    readN = 1'b1;
    waitClk(PHASE);
    check("R6 code kept", code, 14'h1234);

    // R7 clear keeps registers, R8 release by strobe
    clearN = 1'b0;
    waitClk(2 * PHASE);
    check("R7 cleared set", isCleared, 1);
    check("R7 code kept", code, 14'h1234);
    clearN = 1'b1;
    waitClk(2 * PHASE);
    check("R8 stays cleared", isCleared, 1);
    loadN = 1'b0;
    waitClk(2 * PHASE);
    check("R8 strobe release", isCleared, 0);
    check("R8 code restored", code, 14'h1234);
    clearN = 1'b0;
    waitClk(2 * PHASE);
    check("R8 cleared with load held", isCleared, 1);
    clearN = 1'b1;
    waitClk(2 * PHASE);
    check("R8 auto release", isCleared, 0);
    loadN = 1'b1;
    waitClk(PHASE);

    // R7 held input code survives clear: deferred frame, clear, then load
    sendFrame(16'h0ABC, 1'b1, 16, "R5 pass-through d");
    clearN = 1'b0;
    waitClk(2 * PHASE);
    clearN = 1'b1;
    waitClk(PHASE);
    loadN = 1'b0;
    waitClk(2 * PHASE);
    check("R7 held code intact", code, 14'h0ABC);
    check("R8 released", isCleared, 0);
    loadN = 1'b1;
    waitClk(PHASE);

    // R9 power-down
    sleep = 1'b1;
    waitClk(2 * PHASE);
    check("R9 asleep", isAsleep, 1);
    check("R9 code kept", code, 14'h0ABC);
    sleep = 1'b0;
    waitClk(2 * PHASE);
    check("R9 awake", isAsleep, 0);
    check("R9 code kept b", code, 14'h0ABC);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule